// File: doc/BRIEF.md
# Two-Stage APB Watchdog Timer

This peripheral guards a processor against hangs. A 32-bit counter runs down by one on every cycle in which the tick-enable input is high. Each time it runs out it starts again from a programmable reload value. The first time it runs out, the block raises an interrupt. If software has not serviced that interrupt by the next time it runs out, the block requests a system reset and freezes the counter. Both outputs pass through enable bits in a control register.

Software reaches the block through an APB slave port with a 12-bit byte address, which gives a 4 KB window. A lock register protects every other register against stray writes, and only one magic word opens it. A test mode lets software drive the interrupt and reset outputs by hand. Twelve read-only identification bytes sit at the top of the window.

Top module: `wdog_apb`

## Requirements
- R1: After reset the control, lock, test-mode, test-drive, interrupt-status and reset-status state are all zero, the reload value and the counter both hold 0xFFFFFFFF, and the counter is running.
- R2: The control register sits at offset 0x008. Bit 0 enables the interrupt output and bit 1 enables the reset-request output. Writes keep only these two bits, and the other bits always read back as zero.
- R3: A write to offset 0x000 stores the reload value, loads the counter with it at once, and starts the counter if it was stopped. Offset 0x000 reads the reload value and offset 0x004 reads the live count.
- R4: A running counter goes down by one on each cycle with tick_en high. A tick that finds the count at 1 or 0 is an expiry, and it loads the counter from the reload value. At an expiry with no interrupt pending, the raw interrupt status (bit 0 of offset 0x010) is set.
- R5: An expiry that finds the raw interrupt status already set sets the reset status and stops the counter, which then holds the reload value. Only the block reset clears the reset status.
- R6: Any write to offset 0x00C clears the raw interrupt status and loads the counter from the reload value.
- R7: Outside test mode, irq_o is the raw interrupt status AND control bit 0, and rst_req_o is the reset status AND control bit 1. Offset 0x014 reads the masked interrupt in bit 0.
- R8: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value there locks it. A read of 0xC00 returns 1 while locked. While locked, writes to every other offset have no effect.
- R9: When bit 0 of the test-mode register (0xF00) is set, irq_o follows bit 1 of the test-drive register (0xF04) and rst_req_o follows its bit 0. Bit 0 of 0xF00 reads back, and 0xF04 is write-only.
- R10: The twelve words from 0xFD0 to 0xFFC read, in rising address order, 0x04, 0x00, 0x00, 0x00, 0x24, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads of 0x00C, 0xF04 or any unmapped or unaligned offset return zero. Writes to 0x004, 0x010, 0x014, the identification words or unmapped offsets change nothing.
- R12: Every APB access completes in its access phase: pready is 1 and pslverr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| tick_en | input | 1 | Counter decrement enable |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
The hardest state to reach is the escalation. The counter must expire twice with no clear in between, and the bench must then show that the counter has stopped and that the reset status stays set after the interrupt is cleared. The bench holds tick_en low during bus accesses and pulses it for an exact number of cycles, so each expiry falls on a known tick. It uses a small reload value so that both expiries come within a few cycles. It then toggles the reset-enable bit to show the sticky status through rst_req_o. A reload of zero is also loaded, to show that the first tick expires.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 12;

    // word indices (byte offset >> 2)
    localparam logic [AW-3:0] W_RELOAD = 10'h000;
    localparam logic [AW-3:0] W_COUNT  = 10'h001;
    localparam logic [AW-3:0] W_CTRL   = 10'h002;
    localparam logic [AW-3:0] W_ACK    = 10'h003;
    localparam logic [AW-3:0] W_RAW    = 10'h004;
    localparam logic [AW-3:0] W_MASKED = 10'h005;
    localparam logic [AW-3:0] W_GUARD  = 10'h300;
    localparam logic [AW-3:0] W_TMODE  = 10'h3C0;
    localparam logic [AW-3:0] W_TDRIVE = 10'h3C1;
    localparam logic [AW-3:0] W_ID_LO  = 10'h3F4;
    localparam int unsigned   ID_NUM   = 12;

    localparam logic [DW-1:0] UNLOCK_WORD = 32'h1ACC_E551;

    typedef struct packed {
        logic reload;
        logic ack;
        logic ctrl;
        logic guard;
        logic tmode;
        logic tdrive;
    } wr_strobe_t;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = 8'h24;
            4'd5:    id_byte = 8'hB8;
            4'd6:    id_byte = 8'h1B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/wdog_bus.sv
module wdog_bus
    import wdog_pkg::*;
(
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic          locked,
    output wr_strobe_t    wr,
    output logic [AW-3:0] word,
    output logic          aligned
);
    logic access_w;
    logic open_w;

    always_comb begin
        aligned  = (paddr[1:0] == 2'b00);
        word     = paddr[AW-1:2];
        access_w = psel && penable && pwrite && aligned;
        open_w   = access_w && !locked;
        wr       = '0;
        wr.reload = open_w && (word == W_RELOAD);
        wr.ack    = open_w && (word == W_ACK);
        wr.ctrl   = open_w && (word == W_CTRL);
        wr.tmode  = open_w && (word == W_TMODE);
        wr.tdrive = open_w && (word == W_TDRIVE);
        wr.guard  = access_w && (word == W_GUARD);
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  wr_strobe_t    wr,
    input  logic [DW-1:0] wdata,
    output logic [1:0]    ctrl,
    output logic          locked,
    output logic          tmode,
    output logic [1:0]    tdrive
);
    typedef struct packed {
        logic [1:0] ctrl;
        logic       locked;
        logic       tmode;
        logic [1:0] tdrive;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr.ctrl)   r_d.ctrl   = wdata[1:0];
        if (wr.tmode)  r_d.tmode  = wdata[0];
        if (wr.tdrive) r_d.tdrive = wdata[1:0];
        if (wr.guard)  r_d.locked = (wdata != UNLOCK_WORD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl   = r_q.ctrl;
    assign locked = r_q.locked;
    assign tmode  = r_q.tmode;
    assign tdrive = r_q.tdrive;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             do_load,
    input  logic             do_ack,
    input  logic [DW-1:0]    wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             raw,
    output logic             rst_stat,
    output logic             running,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic             raw;
        logic             rst_stat;
        logic             running;
    } cnt_t;

    cnt_t s_d, s_q;
    logic exp_d;

    always_comb begin
        s_d   = s_q;
        exp_d = 1'b0;
        if (do_load) begin
            s_d.reload  = CNT_W'(wdata);
            s_d.count   = CNT_W'(wdata);
            s_d.running = 1'b1;
        end else if (do_ack) begin
            s_d.raw   = 1'b0;
            s_d.count = s_q.reload;
        end else if (s_q.running && tick_en) begin
            if (s_q.count <= CNT_ONE) begin
                exp_d     = 1'b1;
                s_d.count = s_q.reload;
                if (!s_q.raw) begin
                    s_d.raw = 1'b1;
                end else begin
                    s_d.rst_stat = 1'b1;
                    s_d.running  = 1'b0;
                end
            end else begin
                s_d.count = s_q.count - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.count    <= CNT_MAX;
            s_q.reload   <= CNT_MAX;
            s_q.raw      <= 1'b0;
            s_q.rst_stat <= 1'b0;
            s_q.running  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign count    = s_q.count;
    assign reload   = s_q.reload;
    assign raw      = s_q.raw;
    assign rst_stat = s_q.rst_stat;
    assign running  = s_q.running;
    assign expire   = exp_d;
endmodule

// File: rtl/wdog_outmux.sv
module wdog_outmux (
    input  logic       raw,
    input  logic       rst_stat,
    input  logic [1:0] ctrl,
    input  logic       tmode,
    input  logic [1:0] tdrive,
    output logic       masked,
    output logic       irq,
    output logic       rst_req
);
    always_comb begin
        masked = raw & ctrl[0];
        if (tmode) begin
            irq     = tdrive[1];
            rst_req = tdrive[0];
        end else begin
            irq     = masked;
            rst_req = rst_stat & ctrl[1];
        end
    end
endmodule

// File: rtl/wdog_apb.sv
module wdog_apb
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr,
    input  logic          tick_en,
    output logic          irq_o,
    output logic          rst_req_o
);
    localparam logic [AW-3:0] W_ID_HI = W_ID_LO + (AW-2)'(ID_NUM - 1);

    wr_strobe_t       wr;
    logic [AW-3:0]    word;
    logic             aligned;
    logic [1:0]       ctrl;
    logic             locked;
    logic             tmode;
    logic [1:0]       tdrive;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload;
    logic             raw;
    logic             rst_stat;
    logic             running;
    logic             expire;
    logic             masked;
    logic [AW-3:0]    id_off;

    wdog_bus u_bus (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .locked(locked), .wr(wr), .word(word), .aligned(aligned)
    );

    wdog_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(wr), .wdata(pwdata),
        .ctrl(ctrl), .locked(locked), .tmode(tmode), .tdrive(tdrive)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .do_load(wr.reload), .do_ack(wr.ack), .wdata(pwdata),
        .count(count), .reload(reload), .raw(raw), .rst_stat(rst_stat),
        .running(running), .expire(expire)
    );

    wdog_outmux u_out (
        .raw(raw), .rst_stat(rst_stat), .ctrl(ctrl), .tmode(tmode),
        .tdrive(tdrive), .masked(masked), .irq(irq_o), .rst_req(rst_req_o)
    );

    always_comb begin
        id_off = word - W_ID_LO;
        prdata = '0;
        if (aligned) begin
            case (word)
                W_RELOAD: prdata = DW'(reload);
                W_COUNT:  prdata = DW'(count);
                W_CTRL:   prdata = DW'(ctrl);
                W_RAW:    prdata = DW'(raw);
                W_MASKED: prdata = DW'(masked);
                W_GUARD:  prdata = DW'(locked);
                W_TMODE:  prdata = DW'(tmode);
                default: begin
                    if (word >= W_ID_LO && word <= W_ID_HI)
                        prdata = DW'(id_byte(id_off[3:0]));
                end
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/wdog_apb_chk.sv
module wdog_apb_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [11:0]      paddr,
    input logic [31:0]      pwdata,
    input logic             irq_o,
    input logic             rst_req_o,
    input logic             locked,
    input logic [1:0]       ctrl,
    input logic             tmode,
    input logic [1:0]       tdrive,
    input logic [CNT_W-1:0] count,
    input logic             running,
    input logic             raw,
    input logic             rst_stat,
    input logic             expire
);
    logic wr_any, wr_ctrl, wr_load, wr_ack;
    assign wr_any  = psel && penable && pwrite;
    assign wr_ctrl = wr_any && paddr == 12'h008;
    assign wr_load = wr_any && paddr == 12'h000;
    assign wr_ack  = wr_any && paddr == 12'h00C;

    AST_LOCK_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        locked && wr_ctrl |=> $stable(ctrl)); // R8

    AST_LOAD_SETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !locked && wr_load |=> count == $past(pwdata[CNT_W-1:0])); // R3

    AST_ESCALATE: assert property (@(posedge clk) disable iff (!rst_n)
        expire && raw |=> rst_stat && !running); // R5

    AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !wr_load && !wr_ack |=> $stable(count)); // R5

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_stat |=> rst_stat); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !tmode && !ctrl[0] |-> !irq_o); // R7

    AST_TEST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tmode |-> irq_o == tdrive[1] && rst_req_o == tdrive[0]); // R9
endmodule

bind wdog_apb wdog_apb_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .irq_o(irq_o),
    .rst_req_o(rst_req_o), .locked(locked), .ctrl(ctrl), .tmode(tmode),
    .tdrive(tdrive), .count(count), .running(running), .raw(raw),
    .rst_stat(rst_stat), .expire(expire)
);

// File: tb/wdog_apb_test.sv
`timescale 1ns/1ps
module wdog_apb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        tick_en = 1'b0;
    logic        irq_o, rst_req_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    wdog_apb uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .tick_en(tick_en),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    // {write, addr, data, expected read}
    localparam int NV = 26;
    localparam logic [76:0] VEC [NV] = '{
        {1'b1, 12'h008, 32'hFFFF_FFFD, 32'h0}, {1'b0, 12'h008, 32'h0, 32'h1},
        {1'b1, 12'h008, 32'h0, 32'h0},         {1'b0, 12'h008, 32'h0, 32'h0},
        {1'b1, 12'h004, 32'h12, 32'h0},        {1'b0, 12'h004, 32'h0, 32'hFFFF_FFFF},
        {1'b1, 12'h010, 32'h1, 32'h0},         {1'b0, 12'h010, 32'h0, 32'h0},
        {1'b0, 12'h00C, 32'h0, 32'h0},         {1'b0, 12'hF04, 32'h0, 32'h0},
        {1'b0, 12'h018, 32'h0, 32'h0},         {1'b0, 12'h801, 32'h0, 32'h0},
        {1'b1, 12'hFE4, 32'h77, 32'h0},
        {1'b0, 12'hFD0, 32'h0, 32'h04}, {1'b0, 12'hFD4, 32'h0, 32'h00},
        {1'b0, 12'hFD8, 32'h0, 32'h00}, {1'b0, 12'hFDC, 32'h0, 32'h00},
        {1'b0, 12'hFE0, 32'h0, 32'h24}, {1'b0, 12'hFE4, 32'h0, 32'hB8},
        {1'b0, 12'hFE8, 32'h0, 32'h1B}, {1'b0, 12'hFEC, 32'h0, 32'h00},
        {1'b0, 12'hFF0, 32'h0, 32'h0D}, {1'b0, 12'hFF4, 32'h0, 32'hF0},
        {1'b0, 12'hFF8, 32'h0, 32'h05}, {1'b0, 12'hFFC, 32'h0, 32'hB1},
        {1'b0, 12'h000, 32'h0, 32'hFFFF_FFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        chk("R12 pready", 32'(pready), 32'h1);
        chk("R12 pslverr", 32'(pslverr), 32'h0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rchk("R1 count", 12'h004, 32'hFFFF_FFFF);
        rchk("R1 reload", 12'h000, 32'hFFFF_FFFF);
        rchk("R1 ctrl", 12'h008, 32'h0);
        rchk("R1 lock", 12'hC00, 32'h0);
        rchk("R1 tmode", 12'hF00, 32'h0);
        rchk("R1 raw", 12'h010, 32'h0);
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 rst_req", 32'(rst_req_o), 32'h0);

        // table: R2 control mask, R10 ID bytes, R11 ignored/zero offsets
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
            else rchk("R2/R10/R11 table", VEC[i][75:64], VEC[i][31:0]);
        end

        // R3/R4 load and count down
        wr(12'h008, 32'h3);
        wr(12'h000, 32'd5);
        rchk("R3 count after load", 12'h004, 32'd5);
        ticks(3);
        rchk("R4 count after 3 ticks", 12'h004, 32'd2);
        ticks(1);
        chk("R4 no irq before expiry", 32'(irq_o), 32'h0);
        ticks(1);
        chk("R4 irq at first expiry", 32'(irq_o), 32'h1);
        rchk("R4 raw set", 12'h010, 32'h1);
        rchk("R4 reloaded", 12'h004, 32'd5);
        rchk("R7 masked", 12'h014, 32'h1);
        chk("R5 no reset yet", 32'(rst_req_o), 32'h0);

        // R5 escalation
        ticks(4);
        chk("R5 not yet", 32'(rst_req_o), 32'h0);
        ticks(1);
        chk("R5 reset request", 32'(rst_req_o), 32'h1);
        ticks(3);
        rchk("R5 counter frozen", 12'h004, 32'd5);

        // R6 clear, R5 sticky, R7 mask
        wr(12'h00C, 32'h0);
        chk("R6 irq cleared", 32'(irq_o), 32'h0);
        chk("R5 sticky after clear", 32'(rst_req_o), 32'h1);
        wr(12'h008, 32'h1);
        chk("R7 reset masked", 32'(rst_req_o), 32'h0);
        wr(12'h008, 32'h3);
        chk("R5 still set", 32'(rst_req_o), 32'h1);
        wr(12'h008, 32'h1);

        wr(12'h000, 32'd3);
        ticks(3);
        chk("R3 restarted, expiry", 32'(irq_o), 32'h1);
        wr(12'h008, 32'h0);
        chk("R7 irq masked", 32'(irq_o), 32'h0);
        rchk("R7 raw unmasked", 12'h010, 32'h1);
        rchk("R7 masked reg", 12'h014, 32'h0);
        wr(12'h008, 32'h1);
        wr(12'h00C, 32'h0);
        rchk("R6 count reloaded", 12'h004, 32'd3);
        ticks(2);
        rchk("R6 count runs", 12'h004, 32'd1);
        rchk("R6 raw clear", 12'h010, 32'h0);

        // R4 zero reload expires on first tick
        wr(12'h000, 32'd0);
        ticks(1);
        rchk("R4 zero reload expiry", 12'h010, 32'h1);
        wr(12'h00C, 32'h0);

        // R8 lock
        wr(12'hC00, 32'h0);
        rchk("R8 locked reads 1", 12'hC00, 32'h1);
        wr(12'h008, 32'h2);
        rchk("R8 ctrl held", 12'h008, 32'h1);
        wr(12'h000, 32'd7);
        rchk("R8 reload held", 12'h000, 32'd0);
        wr(12'hF00, 32'h1);
        rchk("R8 tmode held", 12'hF00, 32'h0);
        wr(12'hC00, 32'h1ACC_E551);
        rchk("R8 unlocked", 12'hC00, 32'h0);
        wr(12'h008, 32'h0);
        rchk("R8 ctrl writable", 12'h008, 32'h0);

        // R9 test mode
        wr(12'hF04, 32'h2);
        chk("R9 no effect outside mode", 32'(irq_o), 32'h0);
        wr(12'hF00, 32'h1);
        chk("R9 irq driven", 32'(irq_o), 32'h1);
        chk("R9 rst driven low", 32'(rst_req_o), 32'h0);
        wr(12'hF04, 32'h1);
        chk("R9 irq low", 32'(irq_o), 32'h0);
        chk("R9 rst high", 32'(rst_req_o), 32'h1);
        rchk("R9 tmode reads", 12'hF00, 32'h1);
        wr(12'hF00, 32'hFFFF_FFFE);
        chk("R9 mode off irq", 32'(irq_o), 32'h0);
        chk("R9 mode off rst", 32'(rst_req_o), 32'h0);

        finish_run();
    end
endmodule